// File: doc/BRIEF.md
# Translation-Buffer Address Translator

This block turns a 32-bit logical address into a physical address for a processor-side requester. The upper 20 bits of the logical address name a page and the lower 12 bits are an offset inside a 4 KiB page. A small, fully associative translation buffer of recently used page/frame pairs is searched first. When that search misses, the block fetches one page-table entry from memory and copies it into the buffer. The physical address is always the frame number with the untouched offset beside it.

A requester presents an address and an access kind (read, write or execute). It receives exactly one response, which holds either a physical address or a fault code. Two side inputs give the table base and the table length. The table length bounds the legal page numbers before any lookup. Only one request is in flight at a time. A flush input drops every buffered translation, so that software can change the base or length registers safely.

Top module: `addr_xlate`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` and `mem_req` are 0.
- R2: A request is taken on a rising edge with `req_valid` and `req_ready` both high. `req_ready` is then 0 until the response. `rsp_valid` is a single-cycle pulse, and `req_ready` is 1 again in that same cycle.
- R3: A buffer hit is answered in the cycle after acceptance, so `rsp_valid` is high after the second rising edge counted from the accepting edge. A hit issues no memory read.
- R4: A successful response carries `rsp_fault` = 0 and `rsp_paddr` = {frame, offset}. A table entry word is 24 bits: bits [23:4] are the frame, bit 0 is valid, bit 1 is read, bit 2 is write and bit 3 is execute.
- R5: A page number greater than or equal to `pt_len` gives `rsp_fault` = 1 and issues no memory read. This holds even if the buffer holds that page.
- R6: A miss makes a single one-cycle `mem_req` pulse with `mem_addr` = `pt_base` + page number. The response follows one cycle after `mem_rvalid`.
- R7: A fetched entry whose valid bit is 0 gives `rsp_fault` = 2 and is not stored, so a repeat of the same page reads memory again.
- R8: The access codes are 0 read, 1 write and 2 execute. Code 3 always fails the permission check. An access whose permission bit is 0 gives `rsp_fault` = 3. This check applies on hits and on refills, and an entry with a failing permission is still stored.
- R9: A refill goes to the lowest-numbered empty buffer slot. When no slot is empty, it goes to the slot named by a round-robin pointer. That pointer is 0 after reset and advances by one each time a full buffer is refilled.
- R10: A one-cycle `flush` empties every buffer slot, so the next access to any page reads memory.
- R11: Every faulting response has `rsp_paddr` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Empty the translation buffer |
| pt_base | input | 32 | Word address of table entry 0 |
| pt_len | input | 21 | Number of legal pages |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_vaddr | input | 32 | Logical address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_fault | output | 2 | 0 none, 1 range, 2 invalid, 3 protection |
| mem_req | output | 1 | Table entry read pulse |
| mem_addr | output | 32 | Table entry word address |
| mem_rvalid | input | 1 | Table entry data present |
| mem_rdata | input | 24 | Table entry word |

## Verification
The assertions assume several things about the inputs. `pt_base` and `pt_len` stay steady while a request is in flight. Memory answers each `mem_req` with exactly one `mem_rvalid` pulse, and that pulse comes at least one cycle after the request and never without one. Flush is only raised while the block is idle. The stimulus changes base and length and raises flush only between transactions. Its memory model returns each entry one to three cycles after the read pulse and drives data only for a pending read.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    localparam int VA_W  = 32;
    localparam int OFF_W = 12;
    localparam int PN_W  = VA_W - OFF_W;
    localparam int FN_W  = 20;
    localparam int PA_W  = FN_W + OFF_W;
    localparam int PTE_W = FN_W + 4;
    localparam int MA_W  = 32;

    typedef enum logic [1:0] {ACC_RD, ACC_WR, ACC_EX, ACC_RSV} acc_e;
    typedef enum logic [1:0] {FLT_NONE, FLT_RANGE, FLT_INVAL, FLT_PROT} fault_e;

    // perm bits: [0] read, [1] write, [2] execute
    typedef struct packed {
        logic            vld;
        logic [PN_W-1:0] page;
        logic [FN_W-1:0] frame;
        logic [2:0]      perm;
    } tlb_ent_t;

    function automatic logic perm_ok(acc_e a, logic [2:0] p);
        case (a)
            ACC_RD:  return p[0];
            ACC_WR:  return p[1];
            ACC_EX:  return p[2];
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/xlate_victim.sv
module xlate_victim #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vld,
    input  logic [IW-1:0] rr,
    output logic [IW-1:0] idx,
    output logic          full
);
    always_comb begin
        full = &vld;
        idx  = rr;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb
    import xlate_pkg::*;
#(
    parameter int N = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic [PN_W-1:0] lk_page,
    output logic            hit,
    output logic [FN_W-1:0] hit_frame,
    output logic [2:0]      hit_perm,
    input  logic            wr_en,
    input  logic [PN_W-1:0] wr_page,
    input  logic [FN_W-1:0] wr_frame,
    input  logic [2:0]      wr_perm
);
    localparam int IW = $clog2(N);

    typedef struct packed {
        tlb_ent_t [N-1:0] ent;
        logic [IW-1:0]    rr;
    } tlb_st_t;

    tlb_st_t       st_d, st_q;
    logic [N-1:0]  hit_vec;
    logic [N-1:0]  vld_vec;
    logic [IW-1:0] vic_idx;
    logic          vic_full;

    for (genvar gi = 0; gi < N; gi++) begin : g_cmp
        assign vld_vec[gi] = st_q.ent[gi].vld;
        assign hit_vec[gi] = st_q.ent[gi].vld && (st_q.ent[gi].page == lk_page);
    end

    always_comb begin
        hit_frame = '0;
        hit_perm  = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) begin
                hit_frame = hit_frame | st_q.ent[i].frame;
                hit_perm  = hit_perm  | st_q.ent[i].perm;
            end
        end
    end
    assign hit = |hit_vec;

    xlate_victim #(.N(N), .IW(IW)) victim_i (
        .vld  (vld_vec),
        .rr   (st_q.rr),
        .idx  (vic_idx),
        .full (vic_full)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ent[vic_idx].vld   = 1'b1;
            st_d.ent[vic_idx].page  = wr_page;
            st_d.ent[vic_idx].frame = wr_frame;
            st_d.ent[vic_idx].perm  = wr_perm;
            if (vic_full) st_d.rr = (st_q.rr == IW'(N - 1)) ? '0 : st_q.rr + 1'b1;
        end
        if (flush) begin
            for (int i = 0; i < N; i++) st_d.ent[i].vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9: refill only on a miss, so a page never sits in two slots
    a_r9_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R10: after a flush no slot can match
    a_r10_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !hit);
endmodule

// File: rtl/addr_xlate.sv
module addr_xlate
    import xlate_pkg::*;
#(
    parameter int N_ENT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [MA_W-1:0]   pt_base,
    input  logic [PN_W:0]     pt_len,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [1:0]        req_acc,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [1:0]        rsp_fault,
    output logic              mem_req,
    output logic [MA_W-1:0]   mem_addr,
    input  logic              mem_rvalid,
    input  logic [PTE_W-1:0]  mem_rdata
);
    typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_WAIT} st_e;

    typedef struct packed {
        st_e              st;
        logic [PN_W-1:0]  page;
        logic [OFF_W-1:0] off;
        acc_e             acc;
        logic             rsp_v;
        logic [PA_W-1:0]  paddr;
        fault_e           flt;
        logic             mreq;
        logic [MA_W-1:0]  maddr;
    } xl_st_t;

    xl_st_t          s_d, s_q;
    logic            tlb_hit;
    logic [FN_W-1:0] tlb_frame;
    logic [2:0]      tlb_perm;
    logic            wr_en;
    logic [FN_W-1:0] pte_frame;
    logic [2:0]      pte_perm;
    logic            pte_vld;

    assign pte_frame = mem_rdata[PTE_W-1:4];
    assign pte_perm  = mem_rdata[3:1];
    assign pte_vld   = mem_rdata[0];

    xlate_tlb #(.N(N_ENT)) tlb_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .lk_page   (s_q.page),
        .hit       (tlb_hit),
        .hit_frame (tlb_frame),
        .hit_perm  (tlb_perm),
        .wr_en     (wr_en),
        .wr_page   (s_q.page),
        .wr_frame  (pte_frame),
        .wr_perm   (pte_perm)
    );

    always_comb begin
        s_d       = s_q;
        s_d.rsp_v = 1'b0;
        s_d.mreq  = 1'b0;
        wr_en     = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.st   = ST_LOOK;
                    s_d.page = req_vaddr[VA_W-1:OFF_W];
                    s_d.off  = req_vaddr[OFF_W-1:0];
                    s_d.acc  = acc_e'(req_acc);
                end
            end
            ST_LOOK: begin
                s_d.st    = ST_IDLE;
                s_d.rsp_v = 1'b1;
                s_d.paddr = '0;
                if ({1'b0, s_q.page} >= pt_len) begin
                    s_d.flt = FLT_RANGE;
                end else if (tlb_hit) begin
                    if (perm_ok(s_q.acc, tlb_perm)) begin
                        s_d.flt   = FLT_NONE;
                        s_d.paddr = {tlb_frame, s_q.off};
                    end else begin
                        s_d.flt = FLT_PROT;
                    end
                end else begin
                    s_d.rsp_v = 1'b0;
                    s_d.st    = ST_WAIT;
                    s_d.mreq  = 1'b1;
                    s_d.maddr = pt_base + MA_W'(s_q.page);
                end
            end
            ST_WAIT: begin
                if (mem_rvalid) begin
                    s_d.st    = ST_IDLE;
                    s_d.rsp_v = 1'b1;
                    s_d.paddr = '0;
                    if (!pte_vld) begin
                        s_d.flt = FLT_INVAL;
                    end else begin
                        wr_en = 1'b1;
                        if (perm_ok(s_q.acc, pte_perm)) begin
                            s_d.flt   = FLT_NONE;
                            s_d.paddr = {pte_frame, s_q.off};
                        end else begin
                            s_d.flt = FLT_PROT;
                        end
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_ready = (s_q.st == ST_IDLE);
    assign rsp_valid = s_q.rsp_v;
    assign rsp_paddr = s_q.paddr;
    assign rsp_fault = s_q.flt;
    assign mem_req   = s_q.mreq;
    assign mem_addr  = s_q.maddr;

    // R2: busy from the cycle after acceptance
    a_r2_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2: response is a single pulse and returns the block to idle
    a_r2_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (req_ready ##1 !rsp_valid));

    // R5: a table read only ever targets an in-range page
    a_r5_read_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ((mem_addr - pt_base) < MA_W'(pt_len)));

    // R6: one read pulse per miss
    a_r6_one_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R11: faulting responses carry no address
    a_r11_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0));
endmodule

// File: tb/addr_xlate_tb.sv
module addr_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [31:0] pt_base = 32'h0004_0000;
    logic [20:0] pt_len = 21'd16;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [23:0] mem_rdata = '0;

    int          n_chk = 0;
    int          n_bad = 0;
    int          rd_cnt;
    int          lat;
    logic [31:0] last_maddr;
    logic [1:0]  got_flt;
    logic [31:0] got_pa;
    bit          done = 0;

    always #2 clk = ~clk;

    addr_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .flush(flush), .pt_base(pt_base), .pt_len(pt_len),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_acc(req_acc),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    // table entry: [23:4] frame, [3] x, [2] w, [1] r, [0] valid
    function automatic logic [23:0] pte_of(int unsigned pg);
        logic [19:0] fr;
        fr = 20'((pg * 37 + 5) & 32'h000F_FFFF);
        return {fr, ((pg % 4) == 2), ((pg % 3) == 0), ((pg % 5) != 1), ((pg % 7) != 3)};
    endfunction

    task automatic expect_of(input int unsigned pg, input logic [1:0] acc, input logic [11:0] off,
                             output logic [1:0] flt, output logic [31:0] pa);
        logic [23:0] p;
        logic ok;
        pa = '0;
        if (pg >= 32'(pt_len)) begin
            flt = 2'd1;
        end else begin
            p = pte_of(pg);
            if (!p[0]) flt = 2'd2;
            else begin
                ok = (acc == 2'd0) ? p[1] : (acc == 2'd1) ? p[2] : (acc == 2'd2) ? p[3] : 1'b0;
                if (ok) begin flt = 2'd0; pa = {p[23:4], off}; end
                else flt = 2'd3;
            end
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic xlate(input int unsigned pg, input logic [1:0] acc, input logic [11:0] off);
        int pend;
        @(negedge clk);
        req_vaddr = {pg[19:0], off};
        req_acc   = acc;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        rd_cnt = 0;
        pend = 0;
        chk("R2", 32'(req_ready), 32'd0, "ready while busy");
        while (!rsp_valid && lat < 50) begin
            if (mem_rvalid) mem_rvalid = 1'b0;
            if (mem_req) begin
                rd_cnt++;
                last_maddr = mem_addr;
                pend = $urandom_range(1, 3);
            end else if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = pte_of(last_maddr - pt_base);
                end
            end
            @(negedge clk);
            lat++;
        end
        mem_rvalid = 1'b0;
        chk("R2", 32'(rsp_valid), 32'd1, "response seen");
        got_flt = rsp_fault;
        got_pa  = rsp_paddr;
        chk("R2", 32'(req_ready), 32'd1, "ready with response");
    endtask

    task automatic run(input string tag, input int unsigned pg, input logic [1:0] acc, input int exp_reads);
        logic [11:0] off;
        logic [1:0]  eflt;
        logic [31:0] epa;
        off = 12'($urandom);
        xlate(pg, acc, off);
        expect_of(pg, acc, off, eflt, epa);
        chk(tag, 32'(got_flt), 32'(eflt), "fault");
        chk((eflt == 2'd0) ? "R4" : "R11", got_pa, epa, "paddr");
        if (exp_reads >= 0) chk(tag, rd_cnt, exp_reads, "reads");
        if (eflt == 2'd1) chk("R5", rd_cnt, 0, "range reads");
        if (rd_cnt == 1) chk("R6", last_maddr, pt_base + pg, "mem_addr");
        if (rd_cnt == 0) chk("R3", lat, 2, "latency");
    endtask

    task automatic do_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
    endtask

    initial begin
        int unsigned fill [8] = '{0, 1, 2, 4, 5, 6, 8, 9};
        void'($urandom(32'd1357));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 32'(req_ready), 32'd1, "ready");
        chk("R1", 32'(rsp_valid), 32'd0, "rsp_valid");
        chk("R1", 32'(mem_req), 32'd0, "mem_req");

        run("R6", 2, 2'd0, 1);   // miss and refill
        run("R3", 2, 2'd0, 0);   // hit
        run("R8", 2, 2'd1, 0);   // write denied on hit
        run("R8", 2, 2'd3, 0);   // reserved code denied
        run("R4", 2, 2'd2, 0);   // execute allowed
        run("R8", 7, 2'd1, 1);   // write denied on refill
        run("R8", 7, 2'd0, 0);   // denied entry was stored
        run("R7", 3, 2'd0, 1);   // invalid entry
        run("R7", 3, 2'd0, 1);   // not stored
        run("R5", 20, 2'd0, 0);
        run("R5", 16, 2'd0, 0);
        @(negedge clk); pt_len = 21'd2;
        run("R5", 2, 2'd0, 0);   // cached page now out of range
        @(negedge clk); pt_len = 21'd16;
        run("R3", 2, 2'd0, 0);
        do_flush();
        run("R10", 2, 2'd0, 1);

        // replacement order
        do_flush();
        foreach (fill[i]) run("R9", fill[i], 2'd0, 1);
        foreach (fill[i]) run("R9", fill[i], 2'd0, 0);
        run("R9", 11, 2'd0, 1);  // evicts slot 0 (page 0)
        run("R9", 1, 2'd0, 0);
        run("R9", 0, 2'd0, 1);   // evicts slot 1 (page 1)
        run("R9", 1, 2'd0, 1);   // evicts slot 2 (page 2)
        run("R9", 4, 2'd0, 0);

        // random mix
        do_flush();
        @(negedge clk); pt_base = 32'h0123_4000;
        for (int k = 0; k < 400; k++) begin
            run("R4", $urandom_range(0, 19), 2'($urandom_range(0, 3)), -1);
            chk("R6", (rd_cnt <= 1) ? 32'd1 : 32'd0, 32'd1, "at most one read");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R2 watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule